// File: doc/BRIEF.md
# Dirty Band Update Region Tracker

This block walks the per-page modification flags of a framebuffer once per frame and turns them into screen update regions. Every line of the frame occupies a fixed stride, so one page of the 8-bit index plane holds four consecutive scanlines (a band). The tracker reads one flag per clock and joins neighbouring modified bands into a single rectangle. It reports each rectangle as a start line and a line count when a clean band ends the run, or when the frame runs out.

During the walk it also records the lowest and highest modified page. When the walk ends it issues one request to clear that inclusive page range, so the flag store can be reset in a single operation. In wide-colour mode a band also counts as modified when any of the four pages that cover it in the direct-colour plane or in the control plane is flagged. A software driver or display agent pulses the start input once per refresh and waits for the done pulse.

Top module: `dtrk_top`

## Requirements
- R1: After reset, upd_valid_o, clr_valid_o, done_o and flag_req_o are all low, and they stay low until a start pulse is applied.
- R2: Band n covers lines 4n to 4n+3 and is decided by page n. A walk visits bands 0, 1, 2, … while the band's first line is below the height latched at start. A height of 0 visits no band and produces only a done pulse.
- R3: A maximal run of consecutive modified bands that is closed by a clean band produces exactly one update: a one-cycle upd_valid_o pulse with upd_line_o equal to the run's first line and upd_count_o equal to the clean band's first line minus that start.
- R4: A run still open after the last visited band is flushed with upd_count_o equal to the end line minus the start. The end line is the first multiple of 4 that is not below the height, so a height that is not a multiple of 4 rounds the last band up.
- R5: When at least one band was modified, clr_valid_o pulses together with done_o, with clr_lo_o equal to the lowest and clr_hi_o equal to the highest modified index-plane page. When no band was modified, no clear request is made.
- R6: With wide_i high at start, band n reads flag_plane_o code 0 (index) at page n, then code 1 (direct colour) at pages 4n to 4n+3, then code 2 (control) at pages 4n to 4n+3, one read per cycle, and stops at the first set flag. Any one of these nine flags marks the band modified.
- R7: With wide_i low at start, each band makes a single index-plane read. Flags in the direct-colour and control planes have no effect on the updates or the clear range.
- R8: done_o is a one-cycle pulse that ends each walk. It arrives in the same cycle as the final flushed update (if any) and the clear request, after all other updates of that walk, and no flag read follows it.
- R9: A start pulse, or a change of height_i or wide_i, while a walk is in progress is ignored; the walk completes with the values latched at its start.
- R10: Every new walk begins with no open run and an empty page range, whatever the previous walk left behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk over the frame (ignored while busy) |
| height_i | input | LINE_W | Frame height in lines, latched at start (at most 2^LINE_W−4) |
| wide_i | input | 1 | Wide-colour mode, latched at start |
| flag_req_o | output | 1 | A flag read is being made this cycle |
| flag_plane_o | output | 2 | Plane of the read: 0 index, 1 direct colour, 2 control |
| flag_page_o | output | LINE_W | Page number within the selected plane |
| flag_i | input | 1 | Flag value for the addressed page, valid in the same cycle |
| upd_valid_o | output | 1 | One-cycle update rectangle pulse |
| upd_line_o | output | LINE_W | First line of the update rectangle |
| upd_count_o | output | LINE_W | Number of lines in the update rectangle |
| clr_valid_o | output | 1 | Clear request for the flagged page range |
| clr_lo_o | output | LINE_W-2 | Lowest modified index-plane page |
| clr_hi_o | output | LINE_W-2 | Highest modified index-plane page |
| done_o | output | 1 | One-cycle pulse ending the walk |

## Verification
The hardest case to reach from the ports is a band that is modified only through one of the late reads of the wide-colour sequence. Examples are a control-plane page at lane 3 while the index and direct-colour pages are clean, and a run that is still open when a height that is not a multiple of 4 ends the walk. The bench places single flags at chosen plane offsets in its flag memory and picks heights such as 10 and 30, so that both the last-read path and the rounded tail flush are exercised. It also presets the same flags with wide mode off to show that they are ignored. A start pulse with a changed height and mode is injected mid-walk to confirm that the latched values govern the walk.

// File: rtl/dtrk_pkg.sv
package dtrk_pkg;

    typedef enum logic [1:0] {
        PLN_INDEX   = 2'd0,
        PLN_DIRECT  = 2'd1,
        PLN_CONTROL = 2'd2
    } plane_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_TAIL = 2'd2
    } scan_state_e;

    localparam int unsigned LINES_PER_BAND = 4;
    localparam int unsigned WIDE_READS     = 9;

endpackage

// File: rtl/dtrk_band_read.sv
module dtrk_band_read
    import dtrk_pkg::*;
#(
    parameter int unsigned PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              active_i,
    input  logic              wide_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              flag_i,
    output logic              req_o,
    output plane_e            plane_o,
    output logic [PAGE_W+1:0] addr_o,
    output logic              band_done_o,
    output logic              band_dirty_o
);
    localparam int unsigned SUB_W = $clog2(WIDE_READS);
    localparam logic [SUB_W-1:0] LAST_WIDE = SUB_W'(WIDE_READS - 1);

    logic [SUB_W-1:0] sub_d, sub_q;
    logic [SUB_W-1:0] lane_off;
    logic [SUB_W-1:0] last_sub;

    always_comb begin
        lane_off = sub_q - SUB_W'(1);
        last_sub = wide_i ? LAST_WIDE : '0;
        req_o    = active_i;
        if (sub_q == '0) begin
            plane_o = PLN_INDEX;
            addr_o  = {2'b00, page_i};
        end else if (sub_q <= SUB_W'(LINES_PER_BAND)) begin
            plane_o = PLN_DIRECT;
            addr_o  = {page_i, lane_off[1:0]};
        end else begin
            plane_o = PLN_CONTROL;
            addr_o  = {page_i, lane_off[1:0]};
        end
        band_dirty_o = active_i && flag_i;
        band_done_o  = active_i && (flag_i || (sub_q == last_sub));
        if (init_i || band_done_o) begin
            sub_d = '0;
        end else if (active_i) begin
            sub_d = sub_q + SUB_W'(1);
        end else begin
            sub_d = sub_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sub_q <= '0;
        else        sub_q <= sub_d;
    end
endmodule

// File: rtl/dtrk_run_merge.sv
module dtrk_run_merge #(
    parameter int unsigned LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              band_done_i,
    input  logic              band_dirty_i,
    input  logic              tail_i,
    input  logic [LINE_W-1:0] line_i,
    output logic              upd_valid_o,
    output logic [LINE_W-1:0] upd_line_o,
    output logic [LINE_W-1:0] upd_count_o
);
    typedef struct packed {
        logic              open;
        logic [LINE_W-1:0] start;
        logic              vld;
        logic [LINE_W-1:0] line;
        logic [LINE_W-1:0] cnt;
    } merge_t;

    merge_t d, q;

    always_comb begin
        d     = q;
        d.vld = 1'b0;
        if (init_i) begin
            d.open = 1'b0;
        end else if (band_done_i && band_dirty_i) begin
            if (!q.open) begin
                d.open  = 1'b1;
                d.start = line_i;
            end
        end else if ((band_done_i || tail_i) && q.open) begin
            d.open = 1'b0;
            d.vld  = 1'b1;
            d.line = q.start;
            d.cnt  = line_i - q.start;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign upd_valid_o = q.vld;
    assign upd_line_o  = q.line;
    assign upd_count_o = q.cnt;
endmodule

// File: rtl/dtrk_page_span.sv
module dtrk_page_span #(
    parameter int unsigned PAGE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              hit_i,
    input  logic [PAGE_W-1:0] page_i,
    output logic [PAGE_W-1:0] lo_o,
    output logic [PAGE_W-1:0] hi_o,
    output logic              any_o
);
    typedef struct packed {
        logic [PAGE_W-1:0] lo;
        logic [PAGE_W-1:0] hi;
    } span_t;

    span_t d, q;

    always_comb begin
        d = q;
        if (init_i) begin
            d.lo = '1;
            d.hi = '0;
        end else if (hit_i) begin
            if (page_i < q.lo) d.lo = page_i;
            if (page_i > q.hi) d.hi = page_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lo <= '1;
            q.hi <= '0;
        end else begin
            q <= d;
        end
    end

    assign lo_o  = q.lo;
    assign hi_o  = q.hi;
    assign any_o = (q.hi >= q.lo);
endmodule

// File: rtl/dtrk_top.sv
module dtrk_top
    import dtrk_pkg::*;
#(
    parameter int unsigned LINE_W = 12,
    localparam int unsigned PAGE_W = LINE_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LINE_W-1:0] height_i,
    input  logic              wide_i,
    output logic              flag_req_o,
    output logic [1:0]        flag_plane_o,
    output logic [LINE_W-1:0] flag_page_o,
    input  logic              flag_i,
    output logic              upd_valid_o,
    output logic [LINE_W-1:0] upd_line_o,
    output logic [LINE_W-1:0] upd_count_o,
    output logic              clr_valid_o,
    output logic [PAGE_W-1:0] clr_lo_o,
    output logic [PAGE_W-1:0] clr_hi_o,
    output logic              done_o
);
    typedef struct packed {
        scan_state_e       st;
        logic [LINE_W-1:0] line;
        logic [PAGE_W-1:0] page;
        logic [LINE_W-1:0] height;
        logic              wide;
        logic              done;
        logic              clr;
        logic [PAGE_W-1:0] lo;
        logic [PAGE_W-1:0] hi;
    } top_t;

    top_t d, q;

    logic              init;
    logic              scanning;
    logic              tail;
    logic              band_done;
    logic              band_dirty;
    plane_e            rd_plane;
    logic [PAGE_W+1:0] rd_addr;
    logic [PAGE_W-1:0] span_lo, span_hi;
    logic              span_any;
    logic [LINE_W:0]   line_next;

    assign init     = (q.st == ST_IDLE) && start_i;
    assign scanning = (q.st == ST_SCAN);
    assign tail     = (q.st == ST_TAIL);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.clr     = 1'b0;
        line_next = {1'b0, q.line} + (LINE_W+1)'(LINES_PER_BAND);
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.line   = '0;
                    d.page   = '0;
                    d.height = height_i;
                    d.wide   = wide_i;
                    d.st     = (height_i == '0) ? ST_TAIL : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (band_done) begin
                    d.line = line_next[LINE_W-1:0];
                    d.page = q.page + PAGE_W'(1);
                    if (line_next >= {1'b0, q.height}) d.st = ST_TAIL;
                end
            end
            ST_TAIL: begin
                d.done = 1'b1;
                d.clr  = span_any;
                d.lo   = span_lo;
                d.hi   = span_hi;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    dtrk_band_read #(.PAGE_W(PAGE_W)) u_read (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init),
        .active_i     (scanning),
        .wide_i       (q.wide),
        .page_i       (q.page),
        .flag_i       (flag_i),
        .req_o        (flag_req_o),
        .plane_o      (rd_plane),
        .addr_o       (rd_addr),
        .band_done_o  (band_done),
        .band_dirty_o (band_dirty)
    );

    dtrk_run_merge #(.LINE_W(LINE_W)) u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init),
        .band_done_i  (band_done),
        .band_dirty_i (band_dirty),
        .tail_i       (tail),
        .line_i       (q.line),
        .upd_valid_o  (upd_valid_o),
        .upd_line_o   (upd_line_o),
        .upd_count_o  (upd_count_o)
    );

    dtrk_page_span #(.PAGE_W(PAGE_W)) u_span (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (init),
        .hit_i  (band_done && band_dirty),
        .page_i (q.page),
        .lo_o   (span_lo),
        .hi_o   (span_hi),
        .any_o  (span_any)
    );

    assign flag_plane_o = rd_plane;
    assign flag_page_o  = rd_addr;
    assign clr_valid_o  = q.clr;
    assign clr_lo_o     = q.lo;
    assign clr_hi_o     = q.hi;
    assign done_o       = q.done;
endmodule

// File: rtl/dtrk_chk.sv
module dtrk_chk #(
    parameter int unsigned LINE_W = 12,
    localparam int unsigned PAGE_W = LINE_W - 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flag_req_o,
    input logic [1:0]        flag_plane_o,
    input logic              upd_valid_o,
    input logic [LINE_W-1:0] upd_line_o,
    input logic [LINE_W-1:0] upd_count_o,
    input logic              clr_valid_o,
    input logic [PAGE_W-1:0] clr_lo_o,
    input logic [PAGE_W-1:0] clr_hi_o,
    input logic              done_o
);
    AST_UPD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> (upd_line_o[1:0] == 2'b00 && upd_count_o[1:0] == 2'b00)); // R2
    AST_UPD_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |-> (upd_count_o != '0)); // R3
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_o |=> !upd_valid_o); // R3
    AST_CLR_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_o |-> (clr_lo_o <= clr_hi_o)); // R5
    AST_CLR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid_o |-> done_o); // R5
    AST_PLANE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        flag_req_o |-> (flag_plane_o != 2'd3)); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !flag_req_o); // R8
endmodule

bind dtrk_top dtrk_chk #(.LINE_W(LINE_W)) u_dtrk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flag_req_o   (flag_req_o),
    .flag_plane_o (flag_plane_o),
    .upd_valid_o  (upd_valid_o),
    .upd_line_o   (upd_line_o),
    .upd_count_o  (upd_count_o),
    .clr_valid_o  (clr_valid_o),
    .clr_lo_o     (clr_lo_o),
    .clr_hi_o     (clr_hi_o),
    .done_o       (done_o)
);

// File: tb/tb_dtrk_top.sv
module tb_dtrk_top;
    localparam int LINE_W = 12;
    localparam int PAGE_W = LINE_W - 2;
    localparam int NPAGE  = 1 << PAGE_W;
    localparam int NWIDE  = 1 << LINE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [LINE_W-1:0] height_i = '0;
    logic              wide_i = 1'b0;
    logic              flag_req_o;
    logic [1:0]        flag_plane_o;
    logic [LINE_W-1:0] flag_page_o;
    logic              flag_i;
    logic              upd_valid_o;
    logic [LINE_W-1:0] upd_line_o;
    logic [LINE_W-1:0] upd_count_o;
    logic              clr_valid_o;
    logic [PAGE_W-1:0] clr_lo_o;
    logic [PAGE_W-1:0] clr_hi_o;
    logic              done_o;

    always #4 clk = ~clk;

    dtrk_top #(.LINE_W(LINE_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .height_i(height_i),
        .wide_i(wide_i), .flag_req_o(flag_req_o), .flag_plane_o(flag_plane_o),
        .flag_page_o(flag_page_o), .flag_i(flag_i), .upd_valid_o(upd_valid_o),
        .upd_line_o(upd_line_o), .upd_count_o(upd_count_o),
        .clr_valid_o(clr_valid_o), .clr_lo_o(clr_lo_o), .clr_hi_o(clr_hi_o),
        .done_o(done_o)
    );

    // flag store: plane 0 index, 1 direct colour, 2 control
    logic idx_m [NPAGE];
    logic dir_m [NWIDE];
    logic ctl_m [NWIDE];

    always_comb begin
        flag_i = 1'b0;
        if (flag_req_o) begin
            case (flag_plane_o)
                2'd0:    flag_i = idx_m[flag_page_o[PAGE_W-1:0]];
                2'd1:    flag_i = dir_m[flag_page_o];
                2'd2:    flag_i = ctl_m[flag_page_o];
                default: flag_i = 1'b0;
            endcase
        end
    end

    typedef struct {
        int    kind;   // 0 update, 1 clear, 2 done
        int    a;
        int    b;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    int   n_done = 0;
    bit   finished = 1'b0;

    task automatic chk(input string tag, input int act, input int expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic pop_cmp(input int kind, input int a, input int b);
        exp_t e;
        if (exp_q.size() == 0) begin
            n_vec++; n_bad++;
            $display("FAIL R8: unexpected event kind %0d (%0d,%0d) expected none", kind, a, b);
            return;
        end
        e = exp_q.pop_front();
        chk({e.tag, " kind"}, kind, e.kind);
        if (e.kind == kind && kind != 2) begin
            chk({e.tag, " a"}, a, e.a);
            chk({e.tag, " b"}, b, e.b);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (upd_valid_o) pop_cmp(0, int'(upd_line_o), int'(upd_count_o));
            if (clr_valid_o) pop_cmp(1, int'(clr_lo_o), int'(clr_hi_o));
            if (done_o) begin
                pop_cmp(2, 0, 0);
                n_done++;
            end
        end
    end

    task automatic wipe();
        for (int i = 0; i < NPAGE; i++) idx_m[i] = 1'b0;
        for (int i = 0; i < NWIDE; i++) begin
            dir_m[i] = 1'b0;
            ctl_m[i] = 1'b0;
        end
    endtask

    task automatic push(input int k, input int a, input int b, input string tag);
        exp_t e;
        e.kind = k; e.a = a; e.b = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // driver: computes the expected events from the requirements, then runs
    task automatic run_frame(input int h, input bit w, input bit poke, input string tag);
        int run = -1;
        int mn = NPAGE - 1;
        int mx = 0;
        int line;
        int target;
        for (line = 0; line < h; line += 4) begin
            int p = line / 4;
            bit dirty = idx_m[p];
            if (w) for (int k = 0; k < 4; k++) dirty |= dir_m[4*p+k] | ctl_m[4*p+k];
            if (dirty) begin
                if (run < 0) run = line;
                if (p < mn) mn = p;
                if (p > mx) mx = p;
            end else if (run >= 0) begin
                push(0, run, line - run, {tag, " R3 update"});
                run = -1;
            end
        end
        if (run >= 0) push(0, run, line - run, {tag, " R4 tail"});
        if (mx >= mn) push(1, mn, mx, {tag, " R5 clear"});
        push(2, 0, 0, {tag, " R8 done"});
        target = n_done + 1;
        @(negedge clk);
        height_i = LINE_W'(h);
        wide_i   = w;
        start_i  = 1'b1;
        @(negedge clk);
        start_i  = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            start_i  = 1'b1;
            height_i = '0;
            wide_i   = ~w;
            @(negedge clk);
            start_i  = 1'b0;
        end
        while (n_done < target) @(negedge clk);
        repeat (12) @(negedge clk);
        chk({tag, " R8 queue drained"}, exp_q.size(), 0);
    endtask

    initial begin
        wipe();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 upd_valid after reset", int'(upd_valid_o), 0);
        chk("R1 clr_valid after reset", int'(clr_valid_o), 0);
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 flag_req after reset", int'(flag_req_o), 0);

        // R3: two runs separated by clean bands
        wipe(); idx_m[1] = 1; idx_m[2] = 1; idx_m[5] = 1;
        run_frame(32, 0, 0, "R3 narrow runs");

        // R5: nothing dirty, no clear
        wipe();
        run_frame(40, 0, 0, "R5 all clean");

        // R2: zero height
        wipe(); idx_m[0] = 1;
        run_frame(0, 0, 0, "R2 zero height");

        // R4: height not multiple of 4, last band rounded up
        wipe(); idx_m[2] = 1;
        run_frame(10, 0, 0, "R4 h10 last band");
        wipe(); idx_m[0] = 1; idx_m[1] = 1; idx_m[2] = 1; idx_m[3] = 1;
        run_frame(10, 0, 0, "R4 h10 full run");

        // R2 R5: only page 0
        wipe(); idx_m[0] = 1;
        run_frame(16, 0, 0, "R2 page zero");

        // R7: direct/control flags ignored in narrow mode
        wipe(); dir_m[13] = 1; ctl_m[19] = 1; ctl_m[3] = 1;
        run_frame(32, 0, 0, "R7 narrow ignores planes");

        // R6: wide mode, late read positions
        run_frame(32, 1, 0, "R6 wide planes");
        wipe(); ctl_m[4*6+3] = 1; dir_m[4*7] = 1; idx_m[9] = 1;
        run_frame(30, 1, 0, "R6 wide lane3 tail");

        // R9: start mid-walk with changed height and mode is ignored
        wipe(); idx_m[3] = 1; idx_m[4] = 1; idx_m[15] = 1; dir_m[40] = 1;
        run_frame(64, 0, 1, "R9 restart ignored");

        // R10: a fresh walk after an open-run frame
        wipe(); idx_m[7] = 1;
        run_frame(32, 0, 0, "R10 first");
        wipe(); idx_m[1] = 1;
        run_frame(16, 0, 0, "R10 second");

        // random patterns, both modes
        for (int r = 0; r < 6; r++) begin
            wipe();
            for (int i = 0; i < 64; i++) idx_m[i] = ($urandom % 3) == 0;
            for (int i = 0; i < 256; i++) begin
                dir_m[i] = ($urandom % 17) == 0;
                ctl_m[i] = ($urandom % 19) == 0;
            end
            run_frame(64 + 4*r + (r % 3), r[0], 0, "R3 R6 random");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL R8: watchdog expired, actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule